// File: doc/BRIEF.md
# VLAN-Aware MAC Forwarding Lookup

This block makes the forwarding decision for each frame that enters a small Ethernet switch. For every frame it receives the destination and source MAC addresses, the filtering ID (FID) the VLAN stage has already picked, the ingress port, and the VLAN facts the ingress stage has resolved: whether the frame's VLAN ID equals the port's default VLAN ID, and which ports are members of that VLAN. One cycle later it returns a port mask, a flood flag and a drop flag.

Two tables drive the decision. The first is a small static table, written through a simple write port. Each static entry holds a MAC address, a per-entry "match FID" flag, an FID and a port mask. The second is a fully associative dynamic table, keyed by FID plus MAC. It learns source addresses on its own and refreshes them when they are seen again. A round-robin sweep ages each dynamic entry and drops it once it has gone unrefreshed for long enough.

Each port has two control bits. One enables ingress filtering. The other enables the discarding of frames whose VLAN ID is not the port's default.

Top module: `mlk_fwd_lookup`

## Requirements
- R1: When the lowest-indexed valid static entry whose MAC equals the destination has its match-FID flag clear, the frame goes to that entry's port mask, whatever the frame's FID. Higher-indexed static entries with the same MAC are ignored.
- R2: When that static entry has its match-FID flag set and its FID equals the frame's FID, the frame goes to the entry's port mask.
- R3: When no static entry is usable, either because none matches or because the matching one fails the FID test, and a dynamic entry holds the frame's FID and destination MAC, the mask is the one-hot of the port stored in that dynamic entry.
- R4: When neither table gives a usable hit, `fwd_flood` is 1 and the mask holds every port except the ingress port.
- R5: The ingress port's bit in `fwd_mask` is always 0. If the only target is the ingress port, the mask is all zeros and `fwd_flood` stays 0.
- R6: A frame whose FID plus source MAC is not in the dynamic table writes a new entry into a free slot. A frame whose FID plus source MAC is already present overwrites that entry's stored port with the new ingress port and resets its age.
- R7: A source MAC with bit 40 set is never learned. Bit 40 is the individual/group bit of the first octet, with that octet held in bits 47:40. A frame that is dropped is never learned either.
- R8: When every dynamic slot is valid, a new FID plus source pair is not stored, and the existing entries keep their contents.
- R9: A dynamic entry that is not refreshed becomes invalid. This happens more than (AGE_MAX-1)·DYN_N·TICK_CYC cycles, and at most AGE_MAX·DYN_N·TICK_CYC cycles, after its last learn or refresh.
- R10: If ingress filtering is enabled for the ingress port p (`port_ctl` bit 2p+1) and bit p of `frm_vmembers` is 0, then `fwd_drop` is 1, the mask is all zeros and `fwd_flood` is 0.
- R11: If discarding of non-default VLANs is enabled for port p (`port_ctl` bit 2p) and `frm_is_pvid` is 0, the frame is dropped in the same way as in R10.
- R12: The outputs for a frame are valid in the cycle after `frm_vld`, as a single-cycle `fwd_vld` pulse. A table update made by one frame, or by a static write, is seen by a frame presented in the very next cycle.
- R13: After reset `fwd_vld` and `fwd_mask` are 0 and both tables are empty, so the first frame floods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_we | input | 1 | Static table write strobe |
| st_idx | input | clog2(ST_N) | Static entry to write |
| st_vld | input | 1 | Valid bit written to the entry |
| st_mac | input | 48 | MAC address written to the entry |
| st_use_fid | input | 1 | Match-FID flag written to the entry |
| st_fid | input | FID_W | FID written to the entry |
| st_mask | input | NPORT | Port mask written to the entry |
| port_ctl | input | 2·NPORT | Per-port pair: bit 2p+1 enables ingress filtering, bit 2p enables discarding of non-default VLANs |
| frm_vld | input | 1 | A frame is presented this cycle |
| frm_da | input | 48 | Destination MAC |
| frm_sa | input | 48 | Source MAC |
| frm_fid | input | FID_W | Filtering ID of the frame |
| frm_port | input | clog2(NPORT) | Ingress port number |
| frm_is_pvid | input | 1 | Frame VLAN ID equals the ingress port's default |
| frm_vmembers | input | NPORT | Member ports of the frame's VLAN |
| fwd_vld | output | 1 | Decision valid |
| fwd_mask | output | NPORT | Egress port mask |
| fwd_flood | output | 1 | No table hit, frame flooded |
| fwd_drop | output | 1 | Frame discarded by a VLAN rule |

## Verification
The bound checker watches the output contract on every cycle. It confirms that `fwd_vld` follows `frm_vld` by exactly one cycle and that the ingress port never appears in the mask. It also confirms that a drop carries an empty mask and no flood, and that a flood carries exactly the all-but-ingress mask.

The choice between static, dynamic and flood outcomes depends on table contents, so it can only be shown by the bench's scenarios. The same holds for FID matching, priority among duplicate static entries, learning and refresh, the full-table case, the two VLAN discard rules, and the bounds of the ageing window. For these the bench sweeps destinations, FIDs and ingress ports against a table model of its own.

// File: rtl/mlk_pkg.sv
package mlk_pkg;

   localparam int MAC_W     = 48;
   localparam int GROUP_BIT = 40;

   typedef logic [MAC_W-1:0] mac_t;

   typedef enum logic [1:0] {
      FWD_FLOOD  = 2'd0,
      FWD_STATIC = 2'd1,
      FWD_DYN    = 2'd2,
      FWD_DROP   = 2'd3
   } fwd_src_e;

   function automatic logic mac_is_group(mac_t m);
      return m[GROUP_BIT];
   endfunction

endpackage

// File: rtl/mlk_st_tbl.sv
// Static MAC table: write port plus a priority lookup (lowest index wins).
module mlk_st_tbl
   import mlk_pkg::*;
#(
   parameter int NPORT = 5,
   parameter int FID_W = 7,
   parameter int ST_N  = 8,
   localparam int STI_W = (ST_N > 1) ? $clog2(ST_N) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [STI_W-1:0] wr_idx,
   input  logic             wr_vld,
   input  mac_t             wr_mac,
   input  logic             wr_use_fid,
   input  logic [FID_W-1:0] wr_fid,
   input  logic [NPORT-1:0] wr_mask,
   input  mac_t             lk_mac,
   input  logic [FID_W-1:0] lk_fid,
   output logic             lk_hit,
   output logic [NPORT-1:0] lk_mask
);

   logic             vld_q  [ST_N];
   mac_t             mac_q  [ST_N];
   logic             ufid_q [ST_N];
   logic [FID_W-1:0] fid_q  [ST_N];
   logic [NPORT-1:0] mask_q [ST_N];

   for (genvar i = 0; i < ST_N; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vld_q[i] <= 1'b0;
         else if (wr_en && wr_idx == STI_W'(i))
            vld_q[i] <= wr_vld;
      end

      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == STI_W'(i)) begin
            mac_q[i]  <= wr_mac;
            ufid_q[i] <= wr_use_fid;
            fid_q[i]  <= wr_fid;
            mask_q[i] <= wr_mask;
         end
      end
   end

   logic             found;
   logic             sel_ufid;
   logic [FID_W-1:0] sel_fid;
   logic [NPORT-1:0] sel_mask;

   always_comb begin
      found    = 1'b0;
      sel_ufid = 1'b0;
      sel_fid  = '0;
      sel_mask = '0;
      for (int i = ST_N - 1; i >= 0; i--) begin
         if (vld_q[i] && mac_q[i] == lk_mac) begin
            found    = 1'b1;
            sel_ufid = ufid_q[i];
            sel_fid  = fid_q[i];
            sel_mask = mask_q[i];
         end
      end
   end

   assign lk_hit  = found && (!sel_ufid || sel_fid == lk_fid);
   assign lk_mask = sel_mask;

endmodule

// File: rtl/mlk_dyn_tbl.sv
// Fully associative learned table keyed by FID + MAC, with a swept age counter.
module mlk_dyn_tbl
   import mlk_pkg::*;
#(
   parameter int NPORT    = 5,
   parameter int FID_W    = 7,
   parameter int DYN_N    = 16,
   parameter int AGE_MAX  = 7,
   parameter int TICK_CYC = 1024,
   localparam int PORT_W = $clog2(NPORT),
   localparam int AGE_W  = $clog2(AGE_MAX + 1),
   localparam int DI_W   = $clog2(DYN_N),
   localparam int TK_W   = $clog2(TICK_CYC)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  mac_t              da,
   input  mac_t              sa,
   input  logic [FID_W-1:0]  fid,
   input  logic [PORT_W-1:0] port,
   input  logic              lrn_en,
   output logic              da_hit,
   output logic [PORT_W-1:0] da_port
);

   logic              vld_q [DYN_N];
   mac_t              mac_q [DYN_N];
   logic [FID_W-1:0]  fid_q [DYN_N];
   logic [PORT_W-1:0] prt_q [DYN_N];
   logic [AGE_W-1:0]  age_q [DYN_N];

   logic [DYN_N-1:0] da_v, sa_v, free_oh, wr_v;
   logic [TK_W-1:0]  tk_q;
   logic [DI_W-1:0]  sw_q;
   logic             tick;

   always_comb begin
      free_oh = '0;
      da_port = '0;
      for (int i = 0; i < DYN_N; i++) begin
         da_v[i] = vld_q[i] && mac_q[i] == da && fid_q[i] == fid;
         sa_v[i] = vld_q[i] && mac_q[i] == sa && fid_q[i] == fid;
         if (da_v[i]) da_port = da_port | prt_q[i];
      end
      for (int i = DYN_N - 1; i >= 0; i--) begin
         if (!vld_q[i]) begin
            free_oh    = '0;
            free_oh[i] = 1'b1;
         end
      end
      wr_v = !lrn_en ? '0 : ((|sa_v) ? sa_v : free_oh);
   end

   assign da_hit = |da_v;
   assign tick   = (tk_q == TK_W'(TICK_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tk_q <= '0;
         sw_q <= '0;
      end else begin
         tk_q <= tick ? '0 : tk_q + 1'b1;
         if (tick)
            sw_q <= (sw_q == DI_W'(DYN_N - 1)) ? '0 : sw_q + 1'b1;
      end
   end

   for (genvar i = 0; i < DYN_N; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[i] <= 1'b0;
            age_q[i] <= '0;
         end else if (wr_v[i]) begin
            vld_q[i] <= 1'b1;
            age_q[i] <= '0;
         end else if (tick && sw_q == DI_W'(i) && vld_q[i]) begin
            if (age_q[i] == AGE_W'(AGE_MAX - 1))
               vld_q[i] <= 1'b0;
            else
               age_q[i] <= age_q[i] + 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_v[i]) begin
            mac_q[i] <= sa;
            fid_q[i] <= fid;
            prt_q[i] <= port;
         end
      end
   end

endmodule

// File: rtl/mlk_vlan_gate.sv
// Per-port VLAN discard rules: ingress filtering and non-default-VLAN discard.
module mlk_vlan_gate #(
   parameter int NPORT = 5,
   localparam int PORT_W = $clog2(NPORT)
)(
   input  logic [2*NPORT-1:0] port_ctl,
   input  logic [PORT_W-1:0]  port,
   input  logic               is_pvid,
   input  logic [NPORT-1:0]   members,
   output logic               drop
);

   logic [1:0] ctl;
   logic       member;

   always_comb begin
      ctl    = '0;
      member = 1'b0;
      for (int p = 0; p < NPORT; p++) begin
         if (port == PORT_W'(p)) begin
            ctl    = port_ctl[2*p +: 2];
            member = members[p];
         end
      end
      drop = (ctl[1] && !member) || (ctl[0] && !is_pvid);
   end

endmodule

// File: rtl/mlk_fwd_lookup.sv
module mlk_fwd_lookup
   import mlk_pkg::*;
#(
   parameter int NPORT    = 5,
   parameter int FID_W    = 7,
   parameter int ST_N     = 8,
   parameter int DYN_N    = 16,
   parameter int AGE_MAX  = 7,
   parameter int TICK_CYC = 1024,
   localparam int PORT_W = $clog2(NPORT),
   localparam int STI_W  = (ST_N > 1) ? $clog2(ST_N) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_we,
   input  logic [STI_W-1:0]  st_idx,
   input  logic              st_vld,
   input  logic [47:0]       st_mac,
   input  logic              st_use_fid,
   input  logic [FID_W-1:0]  st_fid,
   input  logic [NPORT-1:0]  st_mask,
   input  logic [2*NPORT-1:0] port_ctl,
   input  logic              frm_vld,
   input  logic [47:0]       frm_da,
   input  logic [47:0]       frm_sa,
   input  logic [FID_W-1:0]  frm_fid,
   input  logic [PORT_W-1:0] frm_port,
   input  logic              frm_is_pvid,
   input  logic [NPORT-1:0]  frm_vmembers,
   output logic              fwd_vld,
   output logic [NPORT-1:0]  fwd_mask,
   output logic              fwd_flood,
   output logic              fwd_drop
);

   localparam logic [NPORT-1:0] ALL_PORTS = '1;

   if (NPORT < 2 || NPORT > 16) begin : g_bad_nport
      $error("mlk_fwd_lookup: NPORT must be 2..16");
   end
   if (DYN_N < 2 || AGE_MAX < 2 || TICK_CYC < 2) begin : g_bad_age
      $error("mlk_fwd_lookup: DYN_N, AGE_MAX and TICK_CYC must be at least 2");
   end
   if (FID_W < 1 || ST_N < 1) begin : g_bad_tbl
      $error("mlk_fwd_lookup: FID_W and ST_N must be positive");
   end

   logic              st_hit, dyn_hit, drop;
   logic [NPORT-1:0]  st_pmask;
   logic [PORT_W-1:0] dyn_port;
   logic              lrn_en;

   mlk_vlan_gate #(.NPORT(NPORT)) u_gate (
      .port_ctl (port_ctl),
      .port     (frm_port),
      .is_pvid  (frm_is_pvid),
      .members  (frm_vmembers),
      .drop     (drop)
   );

   mlk_st_tbl #(.NPORT(NPORT), .FID_W(FID_W), .ST_N(ST_N)) u_st (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (st_we),
      .wr_idx     (st_idx),
      .wr_vld     (st_vld),
      .wr_mac     (st_mac),
      .wr_use_fid (st_use_fid),
      .wr_fid     (st_fid),
      .wr_mask    (st_mask),
      .lk_mac     (frm_da),
      .lk_fid     (frm_fid),
      .lk_hit     (st_hit),
      .lk_mask    (st_pmask)
   );

   assign lrn_en = frm_vld && !drop && !mac_is_group(frm_sa);

   mlk_dyn_tbl #(
      .NPORT(NPORT), .FID_W(FID_W), .DYN_N(DYN_N),
      .AGE_MAX(AGE_MAX), .TICK_CYC(TICK_CYC)
   ) u_dyn (
      .clk     (clk),
      .rst_n   (rst_n),
      .da      (frm_da),
      .sa      (frm_sa),
      .fid     (frm_fid),
      .port    (frm_port),
      .lrn_en  (lrn_en),
      .da_hit  (dyn_hit),
      .da_port (dyn_port)
   );

   fwd_src_e         src;
   logic [NPORT-1:0] in_oh, nxt_mask;

   always_comb begin
      in_oh = NPORT'(1) << frm_port;
      if (drop) begin
         src      = FWD_DROP;
         nxt_mask = '0;
      end else if (st_hit) begin
         src      = FWD_STATIC;
         nxt_mask = st_pmask & ~in_oh;
      end else if (dyn_hit) begin
         src      = FWD_DYN;
         nxt_mask = (NPORT'(1) << dyn_port) & ~in_oh;
      end else begin
         src      = FWD_FLOOD;
         nxt_mask = ALL_PORTS & ~in_oh;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_vld   <= 1'b0;
         fwd_mask  <= '0;
         fwd_flood <= 1'b0;
         fwd_drop  <= 1'b0;
      end else begin
         fwd_vld <= frm_vld;
         if (frm_vld) begin
            fwd_mask  <= nxt_mask;
            fwd_flood <= (src == FWD_FLOOD);
            fwd_drop  <= (src == FWD_DROP);
         end
      end
   end

endmodule

// File: rtl/mlk_fwd_chk.sv
module mlk_fwd_chk #(
   parameter int NPORT = 5,
   localparam int PORT_W = $clog2(NPORT)
)(
   input logic              clk,
   input logic              rst_n,
   input logic              frm_vld,
   input logic [PORT_W-1:0] frm_port,
   input logic              fwd_vld,
   input logic [NPORT-1:0]  fwd_mask,
   input logic              fwd_flood,
   input logic              fwd_drop
);

   logic [PORT_W-1:0] port_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       port_q <= '0;
      else if (frm_vld) port_q <= frm_port;
   end

   p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |=> fwd_vld);

   p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_vld |=> !fwd_vld);

   p_no_hairpin_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_vld |-> !fwd_mask[port_q]);

   p_drop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_vld && fwd_drop) |-> (fwd_mask == '0 && !fwd_flood));

   p_flood_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_vld && fwd_flood) |-> (fwd_mask == ({NPORT{1'b1}} & ~(NPORT'(1) << port_q))));

endmodule

bind mlk_fwd_lookup mlk_fwd_chk #(.NPORT(NPORT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frm_vld   (frm_vld),
   .frm_port  (frm_port),
   .fwd_vld   (fwd_vld),
   .fwd_mask  (fwd_mask),
   .fwd_flood (fwd_flood),
   .fwd_drop  (fwd_drop)
);

// File: tb/tb_mlk_fwd_lookup.sv
`timescale 1ns/1ps
module tb_mlk_fwd_lookup;

   localparam int NP = 5, FW = 4, SN = 4, DN = 4, AM = 7, TK = 64;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        st_we = 1'b0, st_vld = 1'b0, st_use_fid = 1'b0;
   logic [1:0]  st_idx = '0;
   logic [47:0] st_mac = '0;
   logic [FW-1:0] st_fid = '0;
   logic [NP-1:0] st_mask = '0;
   logic [2*NP-1:0] ctl = '0;
   logic        frm_vld = 1'b0, frm_is_pvid = 1'b1;
   logic [47:0] frm_da = '0, frm_sa = '0;
   logic [FW-1:0] frm_fid = '0;
   logic [2:0]  frm_port = '0;
   logic [NP-1:0] frm_vmembers = '1;
   logic        fwd_vld, fwd_flood, fwd_drop;
   logic [NP-1:0] fwd_mask;

   always #4 clk = ~clk;

   mlk_fwd_lookup #(.NPORT(NP), .FID_W(FW), .ST_N(SN), .DYN_N(DN),
                    .AGE_MAX(AM), .TICK_CYC(TK)) dut (
      .clk(clk), .rst_n(rst_n), .st_we(st_we), .st_idx(st_idx), .st_vld(st_vld),
      .st_mac(st_mac), .st_use_fid(st_use_fid), .st_fid(st_fid), .st_mask(st_mask),
      .port_ctl(ctl), .frm_vld(frm_vld), .frm_da(frm_da), .frm_sa(frm_sa),
      .frm_fid(frm_fid), .frm_port(frm_port), .frm_is_pvid(frm_is_pvid),
      .frm_vmembers(frm_vmembers), .fwd_vld(fwd_vld), .fwd_mask(fwd_mask),
      .fwd_flood(fwd_flood), .fwd_drop(fwd_drop));

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // model state
   bit          m_sv [SN];
   logic [47:0] m_smac [SN];
   bit          m_suse [SN];
   logic [FW-1:0] m_sfid [SN];
   logic [NP-1:0] m_smask [SN];
   bit          m_dv [DN];
   logic [47:0] m_dmac [DN];
   logic [FW-1:0] m_dfid [DN];
   int          m_dprt [DN];

   logic [NP-1:0] g_mask;
   logic g_flood, g_drop, g_vld;

   localparam logic [47:0] S0 = 48'h0000_1111_0000, S1 = 48'h0000_2222_0000,
                           S3 = 48'h0000_3333_0000, D1 = 48'h0000_4444_0000,
                           UNK = 48'h0000_5555_0000, GRP = 48'h0100_0000_0077;

   task automatic chk(string tag, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model_fwd(input logic [47:0] da, input logic [FW-1:0] fid, input int p,
                            input bit pvid, input logic [NP-1:0] mem,
                            output logic [NP-1:0] em, output logic ef, output logic ed,
                            output string tag);
      logic [NP-1:0] in_oh;
      int si;
      in_oh = NP'(1) << p;
      em = '0; ef = 1'b0; ed = 1'b0;
      if ((ctl[2*p+1] && !mem[p]) || (ctl[2*p] && !pvid)) begin
         ed = 1'b1; tag = ctl[2*p+1] && !mem[p] ? "R10" : "R11"; return;
      end
      si = -1;
      for (int i = SN - 1; i >= 0; i--) if (m_sv[i] && m_smac[i] == da) si = i;
      if (si >= 0 && !m_suse[si]) begin em = m_smask[si] & ~in_oh; tag = "R1"; return; end
      if (si >= 0 && m_sfid[si] == fid) begin em = m_smask[si] & ~in_oh; tag = "R2"; return; end
      for (int i = 0; i < DN; i++)
         if (m_dv[i] && m_dmac[i] == da && m_dfid[i] == fid) begin
            em = (NP'(1) << m_dprt[i]) & ~in_oh; tag = "R3"; return;
         end
      em = ~in_oh; ef = 1'b1; tag = "R4";
   endtask

   task automatic model_learn(input logic [47:0] sa, input logic [FW-1:0] fid, input int p);
      for (int i = 0; i < DN; i++)
         if (m_dv[i] && m_dmac[i] == sa && m_dfid[i] == fid) begin m_dprt[i] = p; return; end
      for (int i = 0; i < DN; i++)
         if (!m_dv[i]) begin
            m_dv[i] = 1'b1; m_dmac[i] = sa; m_dfid[i] = fid; m_dprt[i] = p; return;
         end
   endtask

   task automatic drive(input logic [47:0] da, sa, input logic [FW-1:0] fid, input int p,
                        input bit pvid, input logic [NP-1:0] mem);
      frm_da = da; frm_sa = sa; frm_fid = fid; frm_port = 3'(p);
      frm_is_pvid = pvid; frm_vmembers = mem; frm_vld = 1'b1;
   endtask

   task automatic grab();
      g_mask = fwd_mask; g_flood = fwd_flood; g_drop = fwd_drop; g_vld = fwd_vld;
   endtask

   task automatic send_chk(input logic [47:0] da, sa, input logic [FW-1:0] fid, input int p,
                           input bit pvid, input logic [NP-1:0] mem);
      logic [NP-1:0] em; logic ef, ed; string tag;
      model_fwd(da, fid, p, pvid, mem, em, ef, ed, tag);
      @(negedge clk); drive(da, sa, fid, p, pvid, mem);
      @(negedge clk); frm_vld = 1'b0; grab();
      chk(tag, "mask", g_mask, em);
      chk(tag, "flood", g_flood, ef);
      chk(tag, "drop", g_drop, ed);
      chk("R5", "ingress bit", g_mask[p], 0);
      if (!ed && !sa[40]) model_learn(sa, fid, p);
   endtask

   task automatic st_write(input int idx, input bit v, input logic [47:0] mac, input bit u,
                           input logic [FW-1:0] fid, input logic [NP-1:0] mask);
      @(negedge clk);
      st_we = 1'b1; st_idx = 2'(idx); st_vld = v; st_mac = mac;
      st_use_fid = u; st_fid = fid; st_mask = mask;
      @(negedge clk); st_we = 1'b0;
      m_sv[idx] = v; m_smac[idx] = mac; m_suse[idx] = u; m_sfid[idx] = fid; m_smask[idx] = mask;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; frm_vld = 1'b0; st_we = 1'b0; ctl = '0;
      for (int i = 0; i < SN; i++) m_sv[i] = 1'b0;
      for (int i = 0; i < DN; i++) m_dv[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R12 watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [47:0] das [5];
      logic [FW-1:0] fids [3];
      das[0] = S0; das[1] = S1; das[2] = S3; das[3] = D1; das[4] = UNK;
      fids[0] = 4'd3; fids[1] = 4'd5; fids[2] = 4'd9;

      // ---- reset state (R13)
      do_reset();
      grab();
      chk("R13", "fwd_vld after reset", g_vld, 0);
      chk("R13", "fwd_mask after reset", g_mask, 0);
      send_chk(UNK, GRP, 4'd1, 2, 1'b1, '1);
      chk("R13", "first frame floods", g_flood, 1);

      // ---- static load: entry2 duplicates S0 to test priority (R1)
      st_write(0, 1'b1, S0, 1'b0, 4'd0, 5'b10111);
      st_write(1, 1'b1, S1, 1'b1, 4'd3, 5'b01101);
      st_write(2, 1'b1, S0, 1'b0, 4'd0, 5'b00001);
      st_write(3, 1'b0, S3, 1'b0, 4'd0, 5'b11111);
      send_chk(S1, GRP, 4'd5, 2, 1'b1, '1);      // learns nothing (group SA)
      send_chk(UNK, S1, 4'd5, 2, 1'b1, '1);      // learn (5,S1)->2 (R6)
      send_chk(UNK, D1, 4'd3, 4, 1'b1, '1);      // learn (3,D1)->4 (R6)

      // ---- sweep destination x FID x ingress port (R1..R5)
      for (int d = 0; d < 5; d++)
         for (int f = 0; f < 3; f++)
            for (int p = 0; p < NP; p++)
               send_chk(das[d], GRP, fids[f], p, 1'b1, '1);

      // explicit corner cases
      send_chk(S0, GRP, 4'd9, 1, 1'b1, '1);
      chk("R1", "lowest static index wins", g_mask, 5'b10101);
      send_chk(S1, GRP, 4'd5, 0, 1'b1, '1);
      chk("R3", "FID mismatch falls to dynamic", g_mask, 5'b00100);
      send_chk(D1, GRP, 4'd3, 4, 1'b1, '1);
      chk("R5", "dynamic target is ingress", g_mask, 0);
      chk("R5", "no flood on hairpin", g_flood, 0);

      // ---- back-to-back learn then use (R12)
      @(negedge clk); drive(UNK, 48'h0000_6666_0000, 4'd2, 1, 1'b1, '1);
      @(negedge clk); grab();
      chk("R12", "fwd_vld one cycle after frame", g_vld, 1);
      drive(48'h0000_6666_0000, GRP, 4'd2, 0, 1'b1, '1);
      @(negedge clk); frm_vld = 1'b0; grab();
      chk("R12", "learn seen by next frame", g_mask, 5'b00010);
      @(negedge clk); grab();
      chk("R12", "fwd_vld single pulse", g_vld, 0);
      model_learn(48'h0000_6666_0000, 4'd2, 1);

      // ---- group SA never learned (R7)
      send_chk(UNK, GRP, 4'd1, 2, 1'b1, '1);
      send_chk(GRP, 48'h0100_0000_0001, 4'd1, 0, 1'b1, '1);
      chk("R7", "group SA not learned", g_flood, 1);

      // ---- ingress filtering on port 3 (R10)
      ctl = 10'b00_1000_0000;
      send_chk(UNK, 48'h0000_7777_0000, 4'd1, 3, 1'b1, 5'b10111);
      chk("R10", "non-member dropped", g_drop, 1);
      send_chk(48'h0000_7777_0000, GRP, 4'd1, 0, 1'b1, '1);
      chk("R7", "dropped frame not learned", g_flood, 1);
      send_chk(UNK, GRP, 4'd1, 3, 1'b1, 5'b01000);
      chk("R10", "member forwarded", g_drop, 0);

      // ---- discard of non-default VLAN on port 2 (R11)
      ctl = 10'b00_0001_0000;
      send_chk(UNK, GRP, 4'd1, 2, 1'b0, '1);
      chk("R11", "non-PVID dropped", g_drop, 1);
      send_chk(UNK, GRP, 4'd1, 2, 1'b1, '1);
      chk("R11", "PVID forwarded", g_drop, 0);
      send_chk(UNK, GRP, 4'd1, 1, 1'b0, '1);
      chk("R11", "other port unaffected", g_drop, 0);
      ctl = '0;

      // ---- refresh updates port (R6)
      send_chk(UNK, D1, 4'd3, 1, 1'b1, '1);
      send_chk(D1, GRP, 4'd3, 0, 1'b1, '1);
      chk("R6", "refresh moved port", g_mask, 5'b00010);

      // ---- full table (R8)
      do_reset();
      for (int i = 1; i <= 4; i++) send_chk(UNK, 48'h0000_0000_0E00 + 48'(i), 4'd1, i, 1'b1, '1);
      send_chk(UNK, 48'h0000_0000_0E05, 4'd1, 1, 1'b1, '1);
      send_chk(48'h0000_0000_0E05, GRP, 4'd1, 0, 1'b1, '1);
      chk("R8", "learn dropped when full", g_flood, 1);
      send_chk(48'h0000_0000_0E01, GRP, 4'd1, 0, 1'b1, '1);
      chk("R8", "existing entry intact", g_mask, 5'b00010);
      send_chk(48'h0000_0000_0E04, GRP, 4'd1, 0, 1'b1, '1);
      chk("R8", "last entry intact", g_mask, 5'b10000);

      // ---- ageing window (R9): (AM-1)*DN*TK = 1536, AM*DN*TK = 1792
      do_reset();
      send_chk(UNK, 48'h0000_0000_0A01, 4'd1, 3, 1'b1, '1);
      repeat (1480) @(negedge clk);
      send_chk(48'h0000_0000_0A01, GRP, 4'd1, 0, 1'b1, '1);
      chk("R9", "entry still present before window", g_mask, 5'b01000);
      repeat (320) @(negedge clk);
      for (int i = 0; i < DN; i++) m_dv[i] = 1'b0;
      send_chk(48'h0000_0000_0A01, GRP, 4'd1, 0, 1'b1, '1);
      chk("R9", "entry aged out after window", g_flood, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule